// File: doc/BRIEF.md
# Read-Only Serial Converter Sequencer

This block drives an external serial analog-to-digital converter that is used only to produce samples. The converter's serial data input is tied low for good, so its configuration is never touched. Every conversion therefore begins with a pulse on the converter's dedicated start pin. After reset the sequencer holds off for the converter's power-up self-calibration. That wait is a cycle count derived from the system clock frequency. After it, each request on `startReq` produces one start pulse and one 16-bit result.

Two read styles are supported, selected by `mode`. In the host-clocked styles the sequencer drives the frame strobe and serial clock itself. Mode 2 first waits for the converter's busy flag to go high and then low. Mode 3 waits a fixed delay of about 200 ns instead and reads while the conversion is still running. In the converter-clocked styles (modes 4 and 5) the converter opens the frame and runs the clock on its own after the start pulse, and the sequencer only samples the data line. Any other mode value, including 1, is rejected and flagged.

Top module: `adcRdHost`

## Requirements
- R1: `dinOut` is 0 in every cycle, during and after reset.
- R2: After reset is released, `ready` stays low and no start pulse is issued for exactly CAL_CYC = CLK_MHZ*CAL_US clock cycles. `ready` is first high in cycle CAL_CYC.
- R3: A `startReq` seen while `ready` is high with `mode` in 2..5 raises `convPulse` for exactly PULSE_CYC cycles. `frameN` stays high while `convPulse` is high.
- R4: In mode 2 the sequencer waits for `busyIn` to go high and then low. `frameN` falls exactly 3 cycles after `busyIn` falls.
- R5: In mode 3 `busyIn` is ignored, and `frameN` falls exactly PULSE_CYC + WAIT_CYC cycles after `convPulse` rises, with WAIT_CYC = ceil(CLK_MHZ*WAIT_NS/1000).
- R6: In modes 2 and 3 `sclkOut` idles low and gives exactly 16 rising edges, all while `frameN` is low. Data is taken from `sdataIn` most significant bit first, each bit valid from the previous falling edge (the first from the frame opening). `result` equals the word sent.
- R7: In modes 4 and 5 `frameN` stays high and `sclkOut` stays low. The word is taken MSB first on the rising edges of `extSclkIn` while `extFrameNIn` is low.
- R8: Each finished word makes `resultValid` high for exactly one cycle, with `result` holding the word in that cycle.
- R9: A `startReq` in idle with `mode` equal to 0, 1, 6 or 7 issues no start pulse and sets `modeErr`. `modeErr` clears on the next accepted request.
- R10: A `startReq` while a conversion or readout is in progress is ignored. Exactly one start pulse and one result follow the accepted request.
- R11: `mode` is captured when a request is accepted. Changes to it during that conversion do not alter its read style.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request one conversion |
| mode | input | 3 | Read style: 2/3 host-clocked, 4/5 converter-clocked |
| busyIn | input | 1 | Converter busy flag (asynchronous) |
| sdataIn | input | 1 | Converter serial data out (asynchronous) |
| extSclkIn | input | 1 | Converter-driven serial clock (asynchronous) |
| extFrameNIn | input | 1 | Converter-driven frame strobe, active low (asynchronous) |
| convPulse | output | 1 | Start-conversion pulse to the converter |
| frameN | output | 1 | Host-driven frame strobe, active low |
| sclkOut | output | 1 | Host-driven serial clock |
| dinOut | output | 1 | Serial data toward the converter, held low |
| result | output | WORD_W | Last received word |
| resultValid | output | 1 | One-cycle strobe marking a new `result` |
| ready | output | 1 | Calibration over and no conversion active |
| modeErr | output | 1 | Last request carried an unsupported mode |

## Verification
The start pulse appears one cycle after the accepted request and lasts PULSE_CYC cycles. In mode 3 the frame opens PULSE_CYC + WAIT_CYC cycles after the pulse rises. In mode 2 it opens three cycles after busy falls: two synchronizer stages and one state register. The valid strobe follows the sixteenth sampled edge by one register. The bench counts cycles at falling clock edges from the request onward and compares each interval against these figures. The timing against busy is measured in simulation time, because the bench's own converter model drives busy. Calibration length is counted edge by edge from reset release, and every test word is checked once the strobe arrives, with extra cycles afterwards to catch a repeated strobe or pulse.

// File: rtl/adcRdPkg.sv
package adcRdPkg;

  typedef enum logic [2:0] {
    ST_CAL, ST_IDLE, ST_PULSE, ST_BUSYHI, ST_BUSYLO, ST_DELAY, ST_HOSTRD, ST_EXTRD
  } rdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadPulse;
    logic loadWait;
    logic runSclk;
    logic shiftHost;
    logic shiftExt;
  } rdCtl_t;

  function automatic logic isHostMode(input logic [2:0] m);
    return (m == 3'd2) || (m == 3'd3);
  endfunction

  function automatic logic isExtMode(input logic [2:0] m);
    return (m == 3'd4) || (m == 3'd5);
  endfunction

endpackage

// File: rtl/adcRdDatapath.sv
module adcRdDatapath
  import adcRdPkg::*;
#(
  parameter int CAL_CYC   = 1000,
  parameter int WAIT_CYC  = 50,
  parameter int PULSE_CYC = 4,
  parameter int SCLK_HALF = 4,
  parameter int WORD_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdCtl_t            ctl,
  input  logic              busyIn,
  input  logic              sdataIn,
  input  logic              extSclkIn,
  input  logic              extFrameNIn,
  output logic              busyS,
  output logic              tmrZero,
  output logic              wordDone,
  output logic              sclkOut,
  output logic [WORD_W-1:0] result,
  output logic              resultValid
);
  localparam int MAXC = (CAL_CYC > WAIT_CYC) ? ((CAL_CYC > PULSE_CYC) ? CAL_CYC : PULSE_CYC)
                                             : ((WAIT_CYC > PULSE_CYC) ? WAIT_CYC : PULSE_CYC);
  localparam int TW = $clog2(MAXC + 1);
  localparam int DW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam int BW = $clog2(WORD_W);
  localparam int NSYNC = 4;
  localparam logic [NSYNC-1:0] SYNC_INIT = 4'b0001;

  // two-stage synchronizers: {busy, data, ext clock, ext frame}
  logic [NSYNC-1:0] rawIn, syncOut;
  assign rawIn = {busyIn, sdataIn, extSclkIn, extFrameNIn};

  for (genvar g = 0; g < NSYNC; g++) begin : gSync
    logic meta, held;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta <= SYNC_INIT[g];
        held <= SYNC_INIT[g];
      end else begin
        meta <= rawIn[g];
        held <= meta;
      end
    end
    assign syncOut[g] = held;
  end

  logic sdataS, extSclkS, extFrameNS;
  assign busyS      = syncOut[3];
  assign sdataS     = syncOut[2];
  assign extSclkS   = syncOut[1];
  assign extFrameNS = syncOut[0];

  // shared down-timer, preloaded with the calibration wait at reset
  logic [TW-1:0] tmr;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              tmr <= TW'(CAL_CYC - 1);
    else if (ctl.loadPulse) tmr <= TW'(PULSE_CYC - 1);
    else if (ctl.loadWait)  tmr <= TW'(WAIT_CYC - 1);
    else if (tmr != '0)     tmr <= tmr - 1'b1;
  end
  assign tmrZero = (tmr == '0);

  // host serial clock generator, idles low
  logic [DW-1:0] divCnt;
  logic sclkReg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      sclkReg <= 1'b0;
    end else if (!ctl.runSclk) begin
      divCnt  <= '0;
      sclkReg <= 1'b0;
    end else if (divCnt == DW'(SCLK_HALF - 1)) begin
      divCnt  <= '0;
      sclkReg <= ~sclkReg;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end
  assign sclkOut = sclkReg;

  // sample points: host clock falling edge, or converter clock rising edge
  logic extSclkPrev;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extSclkPrev <= 1'b0;
    else       extSclkPrev <= extSclkS;
  end

  logic hostFall, extRise, sample;
  assign hostFall = ctl.shiftHost && ctl.runSclk && sclkReg && (divCnt == DW'(SCLK_HALF - 1));
  assign extRise  = ctl.shiftExt && extSclkS && !extSclkPrev && !extFrameNS;
  assign sample   = hostFall || extRise;

  logic [BW-1:0] bitCnt;
  logic [WORD_W-1:0] shiftReg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (!(ctl.shiftHost || ctl.shiftExt)) begin
      bitCnt <= '0;
    end else if (sample) begin
      bitCnt   <= bitCnt + 1'b1;
      shiftReg <= {shiftReg[WORD_W-2:0], sdataS};
    end
  end
  assign wordDone = sample && (bitCnt == BW'(WORD_W - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= wordDone;
      if (wordDone) result <= {shiftReg[WORD_W-2:0], sdataS};
    end
  end

endmodule

// File: rtl/adcRdControl.sv
module adcRdControl
  import adcRdPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] mode,
  input  logic       startReq,
  input  logic       busyS,
  input  logic       tmrZero,
  input  logic       wordDone,
  output rdCtl_t     ctl,
  output logic       convPulse,
  output logic       frameN,
  output logic       ready,
  output logic       modeErr
);
  rdState_t state, nextState;
  logic [2:0] modeQ;
  logic modeOk;

  assign modeOk = isHostMode(mode) || isExtMode(mode);

  always_comb begin
    nextState = state;
    ctl = '0;
    unique case (state)
      ST_CAL:    if (tmrZero) nextState = ST_IDLE;
      ST_IDLE:   if (startReq && modeOk) begin
                   ctl.loadPulse = 1'b1;
                   nextState = ST_PULSE;
                 end
      ST_PULSE:  if (tmrZero) begin
                   if (isExtMode(modeQ))     nextState = ST_EXTRD;
                   else if (modeQ == 3'd2)   nextState = ST_BUSYHI;
                   else begin
                     ctl.loadWait = 1'b1;
                     nextState = ST_DELAY;
                   end
                 end
      ST_BUSYHI: if (busyS)   nextState = ST_BUSYLO;
      ST_BUSYLO: if (!busyS)  nextState = ST_HOSTRD;
      ST_DELAY:  if (tmrZero) nextState = ST_HOSTRD;
      ST_HOSTRD: begin
                   ctl.runSclk   = 1'b1;
                   ctl.shiftHost = 1'b1;
                   if (wordDone) nextState = ST_IDLE;
                 end
      ST_EXTRD:  begin
                   ctl.shiftExt = 1'b1;
                   if (wordDone) nextState = ST_IDLE;
                 end
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_CAL;
      modeQ   <= 3'd2;
      modeErr <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && startReq) begin
        modeErr <= !modeOk;
        if (modeOk) modeQ <= mode;
      end
    end
  end

  assign convPulse = (state == ST_PULSE);
  assign frameN    = (state != ST_HOSTRD);
  assign ready     = (state == ST_IDLE);

endmodule

// File: rtl/adcRdHost.sv
module adcRdHost
  import adcRdPkg::*;
#(
  parameter int CLK_MHZ   = 250,
  parameter int CAL_US    = 42000,
  parameter int WAIT_NS   = 200,
  parameter int PULSE_CYC = 4,
  parameter int SCLK_HALF = 4,
  parameter int WORD_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [2:0]        mode,
  input  logic              busyIn,
  input  logic              sdataIn,
  input  logic              extSclkIn,
  input  logic              extFrameNIn,
  output logic              convPulse,
  output logic              frameN,
  output logic              sclkOut,
  output logic              dinOut,
  output logic [WORD_W-1:0] result,
  output logic              resultValid,
  output logic              ready,
  output logic              modeErr
);
  localparam int CAL_CYC  = CLK_MHZ * CAL_US;
  localparam int WAIT_CYC = (CLK_MHZ * WAIT_NS + 999) / 1000;

  rdCtl_t ctl;
  logic busyS, tmrZero, wordDone;

  // the converter's configuration input is never driven
  assign dinOut = 1'b0;

  adcRdControl uCtl (
    .clk(clk), .rstN(rstN), .mode(mode), .startReq(startReq),
    .busyS(busyS), .tmrZero(tmrZero), .wordDone(wordDone), .ctl(ctl),
    .convPulse(convPulse), .frameN(frameN), .ready(ready), .modeErr(modeErr)
  );

  adcRdDatapath #(
    .CAL_CYC(CAL_CYC), .WAIT_CYC(WAIT_CYC), .PULSE_CYC(PULSE_CYC),
    .SCLK_HALF(SCLK_HALF), .WORD_W(WORD_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busyIn(busyIn), .sdataIn(sdataIn),
    .extSclkIn(extSclkIn), .extFrameNIn(extFrameNIn), .busyS(busyS),
    .tmrZero(tmrZero), .wordDone(wordDone), .sclkOut(sclkOut),
    .result(result), .resultValid(resultValid)
  );

endmodule

// File: rtl/adcRdHostChk.sv
module adcRdHostChk (
  input logic clk,
  input logic rstN,
  input logic convPulse,
  input logic frameN,
  input logic sclkOut,
  input logic resultValid,
  input logic ready,
  input logic modeErr
);
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN) resultValid |=> !resultValid); // R8
  AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN) sclkOut |-> !frameN); // R6
  AST_PULSE_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN) $rose(convPulse) |-> $past(ready)); // R3
  AST_PULSE_FRAME_CLOSED: assert property (@(posedge clk) disable iff (!rstN) convPulse |-> frameN); // R3
  AST_ERR_NO_PULSE: assert property (@(posedge clk) disable iff (!rstN) modeErr |-> !convPulse); // R9
endmodule

bind adcRdHost adcRdHostChk uChk (
  .clk(clk), .rstN(rstN), .convPulse(convPulse), .frameN(frameN),
  .sclkOut(sclkOut), .resultValid(resultValid), .ready(ready), .modeErr(modeErr)
);

// File: tb/adcRdHost_test.sv
`timescale 1ns/1ps
module adcRdHost_test;
  localparam int CLK_MHZ = 250;
  localparam int CAL_US  = 2;
  localparam int WAIT_NS = 200;
  localparam int PCYC    = 4;
  localparam int HALF    = 4;
  localparam int EH      = 5;
  localparam int CALC    = CLK_MHZ * CAL_US;
  localparam int WAITC   = (CLK_MHZ * WAIT_NS + 999) / 1000;

  logic clk = 0, rstN = 0, startReq = 0;
  logic [2:0] mode = 3'd2;
  logic busyIn = 0, sdataIn = 0, extSclkIn = 0, extFrameNIn = 1;
  logic convPulse, frameN, sclkOut, dinOut, resultValid, ready, modeErr;
  logic [15:0] result;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] curWord = '0;
  logic [2:0] curMode = 3'd2;
  int busyLenQ = 40;
  int bitIdx = 15;
  time busyFallT = 0;

  always #2 clk = ~clk;

  adcRdHost #(.CLK_MHZ(CLK_MHZ), .CAL_US(CAL_US), .WAIT_NS(WAIT_NS),
              .PULSE_CYC(PCYC), .SCLK_HALF(HALF), .WORD_W(16)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .mode(mode), .busyIn(busyIn),
    .sdataIn(sdataIn), .extSclkIn(extSclkIn), .extFrameNIn(extFrameNIn),
    .convPulse(convPulse), .frameN(frameN), .sclkOut(sclkOut), .dinOut(dinOut),
    .result(result), .resultValid(resultValid), .ready(ready), .modeErr(modeErr)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // converter model: busy flag
  initial forever begin
    @(posedge convPulse);
    @(negedge clk); busyIn = 1;
    repeat (busyLenQ) @(negedge clk);
    busyIn = 0; busyFallT = $time;
  end

  // converter model: data for host-clocked reads, shifted on falling clock
  initial forever begin
    @(negedge frameN);
    @(negedge clk); bitIdx = 15; sdataIn = curWord[15];
  end
  initial forever begin
    @(negedge sclkOut);
    @(negedge clk);
    if (!frameN && bitIdx > 0) begin
      bitIdx--; sdataIn = curWord[bitIdx];
    end
  end

  // converter model: self-clocked frame after the start pulse
  initial forever begin
    @(posedge convPulse);
    if (curMode >= 3'd4) begin
      @(negedge convPulse);
      repeat (3) @(negedge clk);
      extFrameNIn = 0; sdataIn = curWord[15];
      for (int i = 14; i >= -1; i--) begin
        repeat (EH) @(negedge clk); extSclkIn = 1;
        repeat (EH) @(negedge clk); extSclkIn = 0;
        if (i >= 0) sdataIn = curWord[i];
      end
      extFrameNIn = 1;
    end
  end

  task automatic runConv(input logic [2:0] m, input logic [15:0] w, input bit poke,
                         input bit swapMode, input int busyLen);
    int cyc = 0, pulseRises = 0, pulseHigh = 0, riseCyc = -1, fallCyc = -1;
    int sclkRises = 0, sclkOutside = 0, validCnt = 0, validCyc = 0, dinHigh = 0;
    logic [15:0] got = '0;
    logic prevPulse = 0, prevSclk = 0;
    time fallT = 0;
    curWord = w; curMode = m; busyLenQ = busyLen; mode = m;
    @(negedge clk); startReq = 1;
    while (cyc < 3000 && !(validCnt > 0 && cyc > validCyc + 30)) begin
      @(negedge clk); cyc++;
      startReq = (poke && cyc == 15);
      if (swapMode && cyc == 2) mode = (m >= 3'd4) ? 3'd2 : 3'd4;
      if (convPulse && !prevPulse) begin pulseRises++; if (riseCyc < 0) riseCyc = cyc; end
      if (convPulse) pulseHigh++;
      if (!frameN && fallCyc < 0) begin fallCyc = cyc; fallT = $time; end
      if (sclkOut && !prevSclk && !frameN) sclkRises++;
      if (sclkOut && frameN) sclkOutside++;
      if (dinOut) dinHigh++;
      if (resultValid) begin validCnt++; validCyc = cyc; got = result; end
      prevPulse = convPulse; prevSclk = sclkOut;
    end
    startReq = 0;
    chk(cyc < 3000, "R8 completion before timeout", cyc, 0);
    chk(dinHigh == 0, "R1 dinOut low", dinHigh, 0);
    chk(pulseRises == 1, "R3/R10 one start pulse", pulseRises, 1);
    chk(pulseHigh == PCYC, "R3 pulse width", pulseHigh, PCYC);
    chk(validCnt == 1, "R8/R10 one valid strobe", validCnt, 1);
    chk(got == w, "R6/R7 received word", got, w);
    chk(modeErr == 1'b0, "R9 modeErr clear after good request", modeErr, 0);
    if (m <= 3'd3) begin
      chk(sclkRises == 16, "R6 sclk rising edges in frame", sclkRises, 16);
      chk(sclkOutside == 0, "R6 sclk outside frame", sclkOutside, 0);
      if (m == 3'd2)
        chk(fallT - busyFallT == 12, "R4 frame 3 cycles after busy falls", fallT - busyFallT, 12);
      else
        chk(fallCyc - riseCyc == PCYC + WAITC, "R5 fixed delay to frame", fallCyc - riseCyc, PCYC + WAITC);
    end else begin
      chk(fallCyc == -1, "R7 host frame stays high", fallCyc, -1);
      chk(sclkRises + sclkOutside == 0, "R7 host sclk idle", sclkRises + sclkOutside, 0);
    end
    if (swapMode) chk(got == w, "R11 mode captured at request", got, w);
  endtask

  task automatic badMode(input logic [2:0] m);
    int pulses = 0;
    mode = m;
    @(negedge clk); startReq = 1;
    @(negedge clk); startReq = 0;
    for (int k = 0; k < 20; k++) begin
      if (convPulse) pulses++;
      @(negedge clk);
    end
    chk(pulses == 0, "R9 no pulse for bad mode", pulses, 0);
    chk(modeErr == 1'b1, "R9 modeErr set", modeErr, 1);
    chk(ready == 1'b1, "R9 stays idle", ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n = 0;
    logic [15:0] pat;
    repeat (3) @(negedge clk);
    chk(ready == 0 && convPulse == 0, "R2 idle outputs in reset", {ready, convPulse}, 0);
    chk(frameN == 1 && sclkOut == 0, "R6 frame/sclk idle in reset", {frameN, sclkOut}, 2'b10);
    chk(resultValid == 0 && dinOut == 0, "R1/R8 reset outputs", {resultValid, dinOut}, 0);
    rstN = 1;
    begin
      int pulsesCal = 0;
      while (n < CALC + 100) begin
        @(negedge clk); n++;
        if (convPulse) pulsesCal++;
        if (ready) break;
      end
      chk(n == CALC, "R2 calibration wait length", n, CALC);
      chk(pulsesCal == 0, "R2 no pulse during calibration", pulsesCal, 0);
    end

    // sweep every supported mode over edge and walking-one words
    for (int m = 2; m <= 5; m++) begin
      int bl = (m == 3) ? 120 : 40;
      runConv(3'(m), 16'h0000, 0, 0, bl);
      runConv(3'(m), 16'hFFFF, 0, 0, bl);
      runConv(3'(m), 16'hA5C3, 0, 0, bl);
      runConv(3'(m), 16'h8001, 0, 0, bl);
      for (int b = 0; b < 16; b++) begin
        pat = 16'h1 << b;
        runConv(3'(m), pat, 0, 0, bl);
      end
    end

    // requests while busy are ignored
    runConv(3'd2, 16'h3C5A, 1, 0, 40);
    runConv(3'd3, 16'h1234, 1, 0, 120);
    runConv(3'd4, 16'hBEEF, 1, 0, 40);

    // unsupported modes, each cleared by a good request
    badMode(3'd1); runConv(3'd5, 16'h0F0F, 0, 0, 40);
    badMode(3'd0); runConv(3'd2, 16'hF00D, 0, 0, 40);
    badMode(3'd6); runConv(3'd3, 16'h7E81, 0, 0, 120);
    badMode(3'd7); runConv(3'd4, 16'h55AA, 0, 0, 40);

    // mode changed mid-conversion
    runConv(3'd2, 16'hC3A5, 0, 1, 40);
    runConv(3'd4, 16'h6996, 0, 1, 40);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule